// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Logic

This block is the digital side of a pair of analog comparators. Each raw comparator result arrives with no timing relation to the clock. The block synchronizes it and applies a per-channel polarity inversion. The corrected results are shown in a control/status register. The block keeps a reference copy of the last corrected results. Whenever the live results differ from that copy, it sets a sticky interrupt flag.

The reference copy is updated only when software touches the control/status register. Any read or write of that register re-latches the reference. Until that happens, a persistent difference keeps setting the flag again, even after software clears it. Software can also set the flag to raise an interrupt on purpose. The interrupt request is gated by three enables: a local enable bit, a peripheral enable input and a global enable input. A sleep input turns a flagged, locally enabled event into a wake request. Access is through a small register bus with separate read and write strobes, a 2-bit address and 8-bit data. Read data is registered.

Top module: `cmp_chg_irq`

## Requirements
- R1: After reset, the mode field is 000. Every register reads 0x00. The irq and wake outputs are 0.
- R2: In an active mode, control/status bit 7 equals synchronized channel 1 XOR invert bit 5, and bit 6 equals synchronized channel 0 XOR invert bit 4. A raw input change is visible in a read issued three or more cycles later.
- R3: When an active mode's corrected outputs differ from the reference copy, the flag (flag register, address 1, bit 6) is set at the next clock edge.
- R4: Any read or write of the control/status register (address 0) loads the current corrected outputs into the reference. After that, a flag cleared by software stays clear while the inputs hold still.
- R5: While a difference persists and the control/status register is not accessed, writing 0 to the flag does not leave it clear. The hardware set wins over the software clear.
- R6: Writing 1 to flag bit 6 sets the flag. Writing 0 clears it when no difference is present.
- R7: irq is 1, one cycle after the condition, exactly when the flag, the local enable (address 2, bit 6), per_en and glb_en are all 1. The flag still sets when any of these is 0.
- R8: If a corrected output changes in the same cycle as a control/status read, the change is absorbed into the reference and the flag is not set for it.
- R9: Modes 000 and 111 are powered down. In these modes, bits 7:6 read 0 and no difference is detected.
- R10: wake is 1, one cycle after the condition, exactly when sleep, the flag and the local enable are all 1. Entering or leaving sleep leaves every register unchanged.
- R11: The map is:
  - Address 0 holds the invert bits in 5:4 and the mode in 2:0. Bit 3 reads 0.
  - Addresses 1 and 2 hold only bit 6.
  - Address 3 reads 0.
  - bus_rdata is valid the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cmp_raw | input | 2 | Raw comparator results, asynchronous |
| per_en | input | 1 | Peripheral interrupt enable |
| glb_en | input | 1 | Global interrupt enable |
| sleep | input | 1 | Device is in sleep |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request |

## Verification
A corrupted reference copy shows up in the flag register. The flag either sets with no input change, or fails to stay clear after a control/status access. Either effect is visible within two cycles of the fault, through a flag read or the irq output. A wrong synchronizer or inversion state shows in bits 7:6 of a control/status read three cycles after the input moves. A stuck enable or flag term shows on irq or wake one cycle after the enables are applied.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int NCH      = 2;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 8;
  localparam int MODE_W   = 3;
  localparam int OUT_LSB  = DATA_W - NCH;
  localparam int INV_LSB  = OUT_LSB - NCH;
  localparam int FLAG_BIT = 6;
  localparam logic [ADDR_W-1:0] A_CSR  = 2'd0;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
  localparam logic [ADDR_W-1:0] A_EN   = 2'd2;
  localparam logic [MODE_W-1:0] MODE_RESET = 3'b000;
  localparam logic [MODE_W-1:0] MODE_OFF   = 3'b111;

  function automatic logic mode_on(input logic [MODE_W-1:0] m);
    return (m != MODE_RESET) && (m != MODE_OFF);
  endfunction
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmp_change_det.sv
module cmp_change_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic [W-1:0] live,
  input  logic         relatch,
  input  logic [W-1:0] relatch_val,
  output logic         mismatch
);
  logic [W-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (rst)          ref_q <= '0;
    else if (relatch) ref_q <= relatch_val;
  end

  assign mismatch = active && (live != ref_q);

  // R4: after a relatch with no further change, the copy equals the live value
  a_r4_relatch_settles: assert property (@(posedge clk) disable iff (rst)
    (relatch && $stable(live) && live == relatch_val) |=> !mismatch || $changed(live));
endmodule

// File: rtl/cmp_irq_ctl.sv
module cmp_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set_hw,
  input  logic flag_we,
  input  logic flag_wd,
  input  logic en_we,
  input  logic en_wd,
  input  logic per_en,
  input  logic glb_en,
  input  logic sleep,
  output logic flag,
  output logic en,
  output logic irq,
  output logic wake
);
  logic flag_d;

  always_comb begin
    flag_d = flag_we ? flag_wd : flag;
    if (set_hw) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      en   <= 1'b0;
      irq  <= 1'b0;
      wake <= 1'b0;
    end else begin
      flag <= flag_d;
      if (en_we) en <= en_wd;
      irq  <= flag && en && per_en && glb_en;
      wake <= sleep && flag && en;
    end
  end

  a_r6_sw_set: assert property (@(posedge clk) disable iff (rst)
    (flag_we && flag_wd) |=> flag);
  a_r5_hw_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (set_hw && flag_we && !flag_wd) |=> flag);
  a_r7_no_irq_without_per: assert property (@(posedge clk) disable iff (rst)
    !per_en |=> !irq);
  a_r10_wake_needs_sleep: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(sleep));
endmodule

// File: rtl/cmp_chg_irq.sv
module cmp_chg_irq
  import cmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    cmp_raw,
  input  logic              per_en,
  input  logic              glb_en,
  input  logic              sleep,
  output logic              irq,
  output logic              wake
);
  logic [NCH-1:0]    sync_q, inv_q, live, new_inv, wr_live, relatch_val;
  logic [MODE_W-1:0] mode_q, new_mode;
  logic              active, csr_wr, csr_rd, csr_acc, mismatch, flag, en;
  logic [DATA_W-1:0] rd_mux;

  cmp_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(cmp_raw), .q(sync_q));

  assign csr_wr   = bus_wr && (bus_addr == A_CSR);
  assign csr_rd   = bus_rd && (bus_addr == A_CSR);
  assign csr_acc  = csr_wr || csr_rd;
  assign active   = mode_on(mode_q);
  assign live     = active ? (sync_q ^ inv_q) : '0;
  assign new_inv  = bus_wdata[INV_LSB +: NCH];
  assign new_mode = bus_wdata[MODE_W-1:0];
  assign wr_live  = mode_on(new_mode) ? (sync_q ^ new_inv) : '0;
  assign relatch_val = csr_wr ? wr_live : live;

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q  <= '0;
      mode_q <= MODE_RESET;
    end else if (csr_wr) begin
      inv_q  <= new_inv;
      mode_q <= new_mode;
    end
  end

  cmp_change_det #(.W(NCH)) u_det (
    .clk(clk), .rst(rst), .active(active), .live(live),
    .relatch(csr_acc), .relatch_val(relatch_val), .mismatch(mismatch));

  cmp_irq_ctl u_ctl (
    .clk(clk), .rst(rst),
    .set_hw(mismatch && !csr_acc),
    .flag_we(bus_wr && (bus_addr == A_FLAG)), .flag_wd(bus_wdata[FLAG_BIT]),
    .en_we(bus_wr && (bus_addr == A_EN)),     .en_wd(bus_wdata[FLAG_BIT]),
    .per_en(per_en), .glb_en(glb_en), .sleep(sleep),
    .flag(flag), .en(en), .irq(irq), .wake(wake));

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CSR: begin
        rd_mux[OUT_LSB +: NCH] = live;
        rd_mux[INV_LSB +: NCH] = inv_q;
        rd_mux[MODE_W-1:0]     = mode_q;
      end
      A_FLAG:  rd_mux[FLAG_BIT] = flag;
      A_EN:    rd_mux[FLAG_BIT] = en;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  a_r3_mismatch_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (mismatch && !csr_acc) |=> flag);
  a_r9_off_no_flag_source: assert property (@(posedge clk) disable iff (rst)
    (!active && !flag && !(bus_wr && bus_addr == A_FLAG)) |=> !flag);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!flag && !irq && !wake && mode_q == MODE_RESET));
endmodule

// File: tb/tb_cmp_chg_irq.sv
`timescale 1ns/1ps
module tb_cmp_chg_irq;
  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0, cmp_raw = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic per_en = 1'b0, glb_en = 1'b0, sleep = 1'b0, irq, wake;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_chg_irq dut (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_raw(cmp_raw), .per_en(per_en), .glb_en(glb_en), .sleep(sleep),
    .irq(irq), .wake(wake));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_csr(input logic [2:0] m, input logic [1:0] inv,
                                         input logic [1:0] raw);
    logic act;
    act = (m != 3'd0) && (m != 3'd7);
    return {act ? (raw ^ inv) : 2'b00, inv, 1'b0, m};
  endfunction

  initial begin
    logic [7:0] d;
    idle(3); rst = 1'b0; idle(1);
    // R1 reset state
    rd(2'd0, d); chk("R1 csr", d, 8'h00);
    rd(2'd1, d); chk("R1 flag", d, 8'h00);
    rd(2'd2, d); chk("R1 en", d, 8'h00);
    chk("R1 irq/wake", {6'd0, irq, wake}, 8'h00);

    // R2 R9 R11 sweep over modes, inversions and inputs
    for (int m = 0; m < 8; m++)
      for (int v = 0; v < 4; v++)
        for (int r = 0; r < 4; r++) begin
          wr(2'd0, {2'b11, v[1:0], 1'b1, m[2:0]});
          @(negedge clk); cmp_raw = r[1:0];
          idle(3);
          rd(2'd0, d);
          chk("R2/R9/R11 csr", d, exp_csr(m[2:0], v[1:0], r[1:0]));
        end
    rd(2'd3, d); chk("R11 addr3", d, 8'h00);

    // R9: powered-down mode detects nothing
    wr(2'd0, 8'h07); wr(2'd1, 8'h00); idle(2);
    @(negedge clk); cmp_raw = ~cmp_raw; idle(4);
    rd(2'd1, d); chk("R9 no flag when off", d, 8'h00);

    // R3 R7: change sets flag; irq only with all enables
    wr(2'd0, 8'h01); wr(2'd1, 8'h00); idle(2);
    @(negedge clk); cmp_raw = ~cmp_raw; idle(4);
    rd(2'd1, d); chk("R3 flag set", d, 8'h40);
    for (int e = 0; e < 8; e++) begin
      wr(2'd2, {1'b0, e[0], 6'd0});
      @(negedge clk); per_en = e[1]; glb_en = e[2];
      idle(2);
      chk("R7 irq gate", {7'd0, irq}, {7'd0, e == 7});
    end
    rd(2'd1, d); chk("R7 flag independent", d, 8'h40);

    // R5: clear without access does not stick
    wr(2'd1, 8'h00); idle(2);
    rd(2'd1, d); chk("R5 clear not lasting", d, 8'h40);
    // R4: access relatches; clear then sticks
    rd(2'd0, d); wr(2'd1, 8'h00); idle(3);
    rd(2'd1, d); chk("R4 clear sticks", d, 8'h00);
    wr(2'd0, 8'h12); wr(2'd1, 8'h00); idle(3);
    rd(2'd1, d); chk("R4 write relatches", d, 8'h00);

    // R6 software set and clear
    wr(2'd1, 8'h40); rd(2'd1, d); chk("R6 sw set", d, 8'h40);
    wr(2'd1, 8'h00); rd(2'd1, d); chk("R6 sw clear", d, 8'h00);

    // R8: change in same cycle as csr read is absorbed
    @(negedge clk); cmp_raw = ~cmp_raw;
    @(negedge clk);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 2'd0;
    @(negedge clk); bus_rd = 1'b0;
    idle(3);
    rd(2'd1, d); chk("R8 absorbed", d, 8'h00);

    // R10 wake
    per_en = 1'b0; glb_en = 1'b0;
    wr(2'd2, 8'h40); wr(2'd1, 8'h40);
    @(negedge clk); sleep = 1'b1; idle(2);
    chk("R10 wake on", {7'd0, wake}, 8'h01);
    wr(2'd2, 8'h00); idle(1);
    chk("R10 wake needs en", {7'd0, wake}, 8'h00);
    @(negedge clk); sleep = 1'b0; idle(2);
    rd(2'd0, d); chk("R10 csr kept", d, exp_csr(3'd2, 2'b01, cmp_raw));
    rd(2'd1, d); chk("R10 flag kept", d, 8'h40);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule